// File: doc/BRIEF.md
# Processor Hot-Plug Presence and Event Controller

This block keeps a presence bitmap with one bit per processor ID and a small general-purpose event register block that signals a system control interrupt. A platform agent that adds or removes a processor presents a plug or unplug request with the processor's ID. The block sets or clears the matching presence bit and latches a shared processor-event status flag. The interrupt stays asserted while that flag is both set and enabled. Firmware then reads the bitmap through a byte-wide I/O port to find which processors changed.

The host port is a plain byte-wide I/O window. The bitmap sits at a configurable base and takes one byte per eight IDs. It is read-only: writes are accepted and dropped. The event block holds two status bytes followed by two enable bytes. Status bits are cleared by writing a one, and the enable bytes are ordinary read/write registers. A second event source, the device hot-plug request, shares the interrupt through status bit 1.

Top module: `cpu_hotplug_ctrl`

## Requirements
- R1: After reset the presence bitmap equals the BOOT_MASK parameter (IDs 0 and 1 by default), all event status and enable bytes read 0x00, and `sci` is low.
- R2: A read at bitmap base + k returns presence bits 8k to 8k+7, with ID 8k+j in data bit j. The default base is 0xaf00 and there are 32 bytes for 256 IDs. Reads are combinational from `io_addr`.
- R3: A valid plug request for an ID below N_IDS sets that ID's presence bit, and the bit is readable on the cycle after the request.
- R4: A valid unplug request for an ID below N_IDS clears that ID's presence bit, and the bit is readable on the cycle after the request.
- R5: Every accepted plug or unplug request sets bit 2 (mask 0x04) of status byte 0 at event base + 0 (default 0xafe0).
- R6: Writes to the bitmap address range leave the bitmap unchanged.
- R7: The event block has status bytes at event base + 0 and + 1 and enable bytes at + 2 and + 3. A write to a status byte clears the bits written as one. A write to an enable byte loads the data.
- R8: `dev_hp_evt` sets bit 1 of status byte 0. `sci` is high exactly when (status byte 0 AND enable byte 0) has bit 1 or bit 2 set.
- R9: A request whose ID is N_IDS or above (default 256) changes no presence bit and no status bit.
- R10: If an accepted request and a write-one-to-clear of status bit 2 land in the same cycle, the bit remains set.
- R11: Reads of addresses outside both windows return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Processor plug/unplug request strobe |
| evt_plug | input | 1 | 1 = plug (set bit), 0 = unplug (clear bit) |
| evt_id | input | ID_W (9) | Processor ID of the request |
| dev_hp_evt | input | 1 | Device hot-plug request, sets status bit 1 |
| io_addr | input | 16 | Host I/O byte address |
| io_wr_en | input | 1 | Host byte write strobe |
| io_wr_data | input | 8 | Host write data |
| io_rd_data | output | 8 | Host read data for `io_addr` |
| sci | output | 1 | Level interrupt |

## Verification
The bench targets the boundary IDs 255 and 256. An off-by-one range check would set a stray bit or the status flag for 256, or drop ID 255 from the last bitmap byte. It makes a request and a write-one-to-clear on status bit 2 collide in the same cycle. A design that let the clear win would lose the event and leave `sci` low. It also writes all-ones into the bitmap and moves each interrupt source under different enable masks, which exposes a writable bitmap, a bit 1 / bit 2 swap, or an interrupt that ignores the enables.

// File: rtl/cpu_hotplug_ctrl.sv
module cpu_hotplug_ctrl #(
  parameter int N_IDS = 256,
  parameter int ID_W = 9,
  parameter logic [15:0] MAP_BASE = 16'haf00,
  parameter logic [15:0] GPE_BASE = 16'hafe0,
  parameter logic [N_IDS-1:0] BOOT_MASK = N_IDS'(3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_valid,
  input  logic            evt_plug,
  input  logic [ID_W-1:0] evt_id,
  input  logic            dev_hp_evt,
  input  logic [15:0]     io_addr,
  input  logic            io_wr_en,
  input  logic [7:0]      io_wr_data,
  output logic [7:0]      io_rd_data,
  output logic            sci
);
  localparam int NBYTES = N_IDS / 8;
  localparam int BW = $clog2(NBYTES);
  localparam int IW = $clog2(N_IDS);
  localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(N_IDS);
  localparam logic [7:0] SCI_SRC = 8'h06;

  logic [N_IDS-1:0] present;
  logic [1:0][7:0] sts, sts_nx, en, en_nx;

  wire map_hit = (io_addr >= MAP_BASE) && (io_addr < MAP_BASE + 16'(NBYTES));
  wire gpe_hit = (io_addr >= GPE_BASE) && (io_addr < GPE_BASE + 16'd4);
  wire [BW-1:0] byte_sel = BW'(io_addr - MAP_BASE);
  wire [1:0] gpe_sel = 2'(io_addr - GPE_BASE);
  wire evt_ok = evt_valid && (evt_id < ID_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) present <= BOOT_MASK;
    else if (evt_ok) present[evt_id[IW-1:0]] <= evt_plug;
  end

  always_comb begin
    sts_nx = sts;
    en_nx = en;
    if (io_wr_en && gpe_hit) begin
      if (gpe_sel[1]) en_nx[gpe_sel[0]] = io_wr_data;
      else sts_nx[gpe_sel[0]] = sts[gpe_sel[0]] & ~io_wr_data;
    end
    if (dev_hp_evt) sts_nx[0][1] = 1'b1;
    if (evt_ok) sts_nx[0][2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      en <= '0;
    end else begin
      sts <= sts_nx;
      en <= en_nx;
    end
  end

  always_comb begin
    io_rd_data = 8'h00;
    if (map_hit) io_rd_data = present[{byte_sel, 3'b000} +: 8];
    else if (gpe_hit) io_rd_data = gpe_sel[1] ? en[gpe_sel[0]] : sts[gpe_sel[0]];
  end

  assign sci = |(sts[0] & en[0] & SCI_SRC);

  AST_PLUG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && evt_plug) |=> present[$past(evt_id[IW-1:0])]); // R3
  AST_UNPLUG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && !evt_plug) |=> !present[$past(evt_id[IW-1:0])]); // R4
  AST_EVT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ok |=> sts[0][2]); // R5
  AST_MAP_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_en && map_hit && !evt_valid) |=> $stable(present)); // R6
  AST_IGNORE_BIG_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_id >= ID_LIMIT && !dev_hp_evt && !io_wr_en)
      |=> ($stable(present) && $stable(sts))); // R9
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_ok && io_wr_en && gpe_hit && gpe_sel == 2'd0 && io_wr_data[2]) |=> sts[0][2]); // R10
  AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> |(en[0] & SCI_SRC)); // R8
endmodule

// File: tb/tb_cpu_hotplug_ctrl.sv
module tb_cpu_hotplug_ctrl;
  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_plug = 0, dev_hp_evt = 0, io_wr_en = 0;
  logic [8:0] evt_id = '0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wr_data = '0, io_rd_data;
  logic sci;
  int errors = 0, checks = 0;

  bit m_pres [256];
  logic [7:0] m_sts [2];
  logic [7:0] m_en [2];

  cpu_hotplug_ctrl dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_rd(int a);
    logic [7:0] v = 8'h00;
    if (a >= 'haf00 && a < 'haf20)
      for (int j = 0; j < 8; j++) v[j] = m_pres[(a - 'haf00) * 8 + j];
    else if (a >= 'hafe0 && a < 'hafe2) v = m_sts[a - 'hafe0];
    else if (a >= 'hafe2 && a < 'hafe4) v = m_en[a - 'hafe2];
    return v;
  endfunction

  task automatic step(string tag, int a, bit wr, int wd, bit ev, bit pl, int id, bit dv);
    logic [7:0] er;
    logic es;
    @(negedge clk);
    io_addr = 16'(a); io_wr_en = wr; io_wr_data = 8'(wd);
    evt_valid = ev; evt_plug = pl; evt_id = 9'(id); dev_hp_evt = dv;
    #1;
    er = exp_rd(a);
    es = |(m_sts[0] & m_en[0] & 8'h06);
    checks++;
    if (io_rd_data !== er) begin
      errors++;
      $display("FAIL %s rd_data addr=%h actual=%h expected=%h", tag, a, io_rd_data, er);
    end
    checks++;
    if (sci !== es) begin
      errors++;
      $display("FAIL %s sci actual=%b expected=%b", tag, sci, es);
    end
    @(posedge clk);
    if (wr && a >= 'hafe0 && a < 'hafe2) m_sts[a - 'hafe0] &= ~8'(wd);
    if (wr && a >= 'hafe2 && a < 'hafe4) m_en[a - 'hafe2] = 8'(wd);
    if (dv) m_sts[0][1] = 1'b1;
    if (ev && id < 256) begin
      m_pres[id] = pl;
      m_sts[0][2] = 1'b1;
    end
  endtask

  task automatic rd(string tag, int a);
    step(tag, a, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    foreach (m_pres[i]) m_pres[i] = (i < 2);
    m_sts[0] = 0; m_sts[1] = 0; m_en[0] = 0; m_en[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int k = 0; k < 32; k++) rd("R1", 'haf00 + k);
    for (int k = 0; k < 4; k++) rd("R1", 'hafe0 + k);
    step("R7", 'hafe2, 1, 'h06, 0, 0, 0, 0);
    step("R7", 'hafe3, 1, 'ha5, 0, 0, 0, 0);
    rd("R7", 'hafe2); rd("R7", 'hafe3);
    step("R3", 'haf01, 0, 0, 1, 1, 10, 0);
    rd("R3", 'haf01);
    rd("R5", 'hafe0);
    step("R7", 'hafe0, 1, 'h04, 0, 0, 0, 0);
    rd("R8", 'hafe0);
    step("R4", 'haf00, 0, 0, 1, 0, 0, 0);
    rd("R4", 'haf00);
    step("R7", 'hafe0, 1, 'hff, 0, 0, 0, 0);
    step("R6", 'haf00, 1, 'hff, 0, 0, 0, 0);
    step("R6", 'haf1f, 1, 'hff, 0, 0, 0, 0);
    rd("R6", 'haf00); rd("R6", 'haf1f);
    step("R9", 'hafe0, 0, 0, 1, 1, 256, 0);
    step("R9", 'hafe0, 0, 0, 1, 1, 300, 0);
    rd("R9", 'hafe0);
    for (int k = 0; k < 32; k++) rd("R9", 'haf00 + k);
    step("R2", 'haf1f, 0, 0, 1, 1, 255, 0);
    rd("R2", 'haf1f);
    step("R10", 'hafe0, 1, 'h04, 1, 1, 40, 0);
    rd("R10", 'hafe0);
    step("R10", 'hafe0, 1, 'h04, 0, 0, 0, 0);
    rd("R10", 'hafe0);
    step("R8", 'hafe2, 1, 'h02, 0, 0, 0, 0);
    step("R8", 'hafe0, 0, 0, 1, 1, 3, 0);
    rd("R8", 'hafe0);
    step("R8", 'hafe0, 0, 0, 0, 0, 0, 1);
    rd("R8", 'hafe0);
    step("R8", 'hafe2, 1, 'h04, 0, 0, 0, 0);
    step("R8", 'hafe0, 1, 'h04, 0, 0, 0, 0);
    step("R8", 'hafe2, 1, 'h00, 0, 0, 0, 0);
    rd("R8", 'hafe0);
    rd("R11", 'h1234); rd("R11", 'haf20); rd("R11", 'hafe4); rd("R11", 'haeff);
    for (int id = 0; id < 256; id += 7) step("R3", 'hafe1, 0, 0, 1, 1, id, 0);
    for (int id = 5; id < 256; id += 11) step("R4", 'hafe1, 0, 0, 1, 0, id, 0);
    for (int k = 0; k < 32; k++) rd("R2", 'haf00 + k);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule